// File: doc/BRIEF.md
# Memory-Write Mailbox with Running CRC

This block is a register-mapped mailbox target that lets a host, working through narrow 16-bit management registers, deposit 32-bit words into an embedded processor's memory. The host sets a word address once, as an upper half and a lower half. For each word it then loads the two data halves and issues a write command through the control register. The block drives the word onto a single-port memory write interface and steps the address forward by one word. It also folds the four bytes of the word into a running CRC-16.

A whole image can therefore be streamed with one address setup and one CRC read at the end. The CRC is processed one byte per cycle, with the most significant byte first. While that runs, the control register reports busy and refuses further commands. The host can zero the CRC before a burst through a dedicated control bit.

Top module: `mbox_memwr`

## Requirements
- R1: After reset, all six mailbox registers read 0x0000, busy is 0, the CRC is 0x0000 and `mem_we_o` is low.
- R2: Register offsets are: control 0x0200, CRC 0x0201, address upper 0x0202, address lower 0x0203, data upper 0x0204, data lower 0x0205. The address and data registers read back what was written. Any other offset reads 0x0000, and a write to it changes no register.
- R3: In the address lower register only bits 15:2 are stored, and bits 1:0 read back as 0. The 30-bit word address on `mem_addr_o` is {address upper, address lower[15:2]}.
- R4: A control write while idle with bit 15 (execute) and bit 14 (write) both set raises `mem_we_o` for exactly one cycle, starting the cycle after the write. During that cycle `mem_addr_o` carries the current word address and `mem_wdata_o` carries {data upper, data lower}.
- R5: Each committed word increments the word address by one. A carry out of address lower bit 15 propagates into address upper, and both registers read back the incremented address.
- R6: Control bit 8 (busy) reads 1 during the four cycles that follow an accepted command, and reads 0 from the fifth cycle on.
- R7: While busy is set, a control write has no effect at all: no memory write and no CRC clear. A control write with execute set but write clear causes no memory write.
- R8: The CRC is CRC-16 with polynomial 0x1021, no reflection, no final XOR. It is advanced over each committed word's bytes, most significant byte first. Once busy clears, offset 0x0201 shows the updated value. Writes to 0x0201 are ignored.
- R9: A control write while idle with bit 12 set clears the CRC to 0x0000 in the next cycle. If execute and write are set in the same write, the committed word's CRC starts from 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 16 | Register offset for the current access |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| mem_we_o | output | 1 | Memory write enable, one cycle per word |
| mem_addr_o | output | 30 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
The assertions assume that a register write lasts exactly one cycle and that `reg_wdata_i` is valid whenever `reg_wr_i` is high. They also assume that no control bit outside execute, write and CRC clear carries meaning. The bench drives every access as a single-cycle strobe set up on the falling edge. It reads the busy bit back before issuing the next command, except where it deliberately sends a command into the busy window to exercise R7. Expected memory writes go through a scoreboard queue, so any extra write or any lost write shows up as a miscompare.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W   = 16;
  localparam int WORD_W  = 32;
  localparam int BYTES   = WORD_W / 8;
  localparam int WADDR_W = WORD_W - 2;
  localparam int LO_W    = REG_W - 2;

  localparam logic [15:0] OFF_CTRL    = 16'h0200;
  localparam logic [15:0] OFF_CRC     = 16'h0201;
  localparam logic [15:0] OFF_ADDR_HI = 16'h0202;
  localparam logic [15:0] OFF_ADDR_LO = 16'h0203;
  localparam logic [15:0] OFF_DATA_HI = 16'h0204;
  localparam logic [15:0] OFF_DATA_LO = 16'h0205;

  localparam int BIT_EXEC    = 15;
  localparam int BIT_WRITE   = 14;
  localparam int BIT_CRC_CLR = 12;
  localparam int BIT_BUSY    = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_CRC, SEL_ADDR_HI, SEL_ADDR_LO, SEL_DATA_HI, SEL_DATA_LO
  } reg_sel_e;

  function automatic logic [15:0] crc_byte(input logic [15:0] crc_in,
                                           input logic [7:0]  b,
                                           input logic [15:0] poly);
    logic [15:0] c;
    c = crc_in ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
(
  input  logic [REG_W-1:0] addr_i,
  output reg_sel_e         sel_o
);
  always_comb begin
    unique case (addr_i)
      OFF_CTRL:    sel_o = SEL_CTRL;
      OFF_CRC:     sel_o = SEL_CRC;
      OFF_ADDR_HI: sel_o = SEL_ADDR_HI;
      OFF_ADDR_LO: sel_o = SEL_ADDR_LO;
      OFF_DATA_HI: sel_o = SEL_DATA_HI;
      OFF_DATA_LO: sel_o = SEL_DATA_LO;
      default:     sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  reg_sel_e           sel_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               inc_i,
  output logic [WADDR_W-1:0] waddr_o,
  output logic [WORD_W-1:0]  word_o,
  output logic [REG_W-1:0]   addr_hi_rd_o,
  output logic [REG_W-1:0]   addr_lo_rd_o
);
  logic [WADDR_W-1:0] waddr_q;
  logic [REG_W-1:0]   data_hi_q, data_lo_q;

  // host address writes and auto-increment never coincide: increment needs a control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_q <= '0;
    end else if (wr_i && sel_i == SEL_ADDR_HI) begin
      waddr_q[WADDR_W-1:LO_W] <= wdata_i;
    end else if (wr_i && sel_i == SEL_ADDR_LO) begin
      waddr_q[LO_W-1:0] <= wdata_i[REG_W-1:2];
    end else if (inc_i) begin
      waddr_q <= waddr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_hi_q <= '0;
      data_lo_q <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_DATA_HI) data_hi_q <= wdata_i;
      if (sel_i == SEL_DATA_LO) data_lo_q <= wdata_i;
    end
  end

  assign waddr_o      = waddr_q;
  assign word_o       = {data_hi_q, data_lo_q};
  assign addr_hi_rd_o = waddr_q[WADDR_W-1:LO_W];
  assign addr_lo_rd_o = {waddr_q[LO_W-1:0], 2'b00};
endmodule

// File: rtl/mbox_wr_ctrl.sv
module mbox_wr_ctrl
  import mbox_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               exec_i,
  input  logic               write_i,
  input  logic               clr_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               accept_o,
  output logic               crc_clr_o,
  output logic               busy_o,
  output logic               byte_vld_o,
  output logic [7:0]         byte_o,
  output logic               mem_we_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o
);
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTES - 1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WORD_W-1:0]  shift_q;
  logic               we_q;
  logic [WADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]  data_q;

  assign accept_o  = ctrl_wr_i && !busy_q && exec_i && write_i;
  assign crc_clr_o = ctrl_wr_i && !busy_q && clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (accept_o) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      shift_q <= word_i;
    end else if (busy_q) begin
      shift_q <= shift_q << 8;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= accept_o;
      if (accept_o) begin
        addr_q <= waddr_i;
        data_q <= word_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign byte_vld_o  = busy_q;
  assign byte_o      = shift_q[WORD_W-1 -: 8];
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
endmodule

// File: rtl/mbox_crc_engine.sv
module mbox_crc_engine
  import mbox_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] SEED = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        vld_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= SEED;
    else if (clr_i) crc_q <= SEED;
    else if (vld_i) crc_q <= crc_byte(crc_q, byte_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mbox_memwr.sv
module mbox_memwr
  import mbox_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'h0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_W-1:0]   reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               mem_we_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o
);
  reg_sel_e           sel;
  logic               accept, crc_clr, busy, byte_vld;
  logic [7:0]         byte_val;
  logic [WADDR_W-1:0] waddr;
  logic [WORD_W-1:0]  word;
  logic [REG_W-1:0]   addr_hi_rd, addr_lo_rd;
  logic [15:0]        crc_val;

  mbox_decode u_dec (.addr_i(reg_addr_i), .sel_o(sel));

  mbox_regfile u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .sel_i(sel), .wdata_i(reg_wdata_i), .inc_i(accept),
    .waddr_o(waddr), .word_o(word),
    .addr_hi_rd_o(addr_hi_rd), .addr_lo_rd_o(addr_lo_rd)
  );

  mbox_wr_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .ctrl_wr_i(reg_wr_i && sel == SEL_CTRL),
    .exec_i(reg_wdata_i[BIT_EXEC]), .write_i(reg_wdata_i[BIT_WRITE]),
    .clr_i(reg_wdata_i[BIT_CRC_CLR]),
    .waddr_i(waddr), .word_i(word),
    .accept_o(accept), .crc_clr_o(crc_clr), .busy_o(busy),
    .byte_vld_o(byte_vld), .byte_o(byte_val),
    .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  mbox_crc_engine #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk_i, .rst_ni,
    .clr_i(crc_clr), .vld_i(byte_vld), .byte_i(byte_val), .crc_o(crc_val)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_CTRL:    reg_rdata_o[BIT_BUSY] = busy;
      SEL_CRC:     reg_rdata_o = crc_val;
      SEL_ADDR_HI: reg_rdata_o = addr_hi_rd;
      SEL_ADDR_LO: reg_rdata_o = addr_lo_rd;
      SEL_DATA_HI: reg_rdata_o = word[WORD_W-1:REG_W];
      SEL_DATA_LO: reg_rdata_o = word[REG_W-1:0];
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_memwr_chk.sv
module mbox_memwr_chk
  import mbox_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             mem_we_o,
  input logic             busy_i,
  input logic [15:0]      crc_i
);
  logic ctrl_wr, cmd_ok;
  assign ctrl_wr = reg_wr_i && reg_addr_i == OFF_CTRL;
  assign cmd_ok  = reg_wdata_i[BIT_EXEC] && reg_wdata_i[BIT_WRITE];

  a_r4_commit_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !busy_i && cmd_ok |=> mem_we_o);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  a_r6_busy_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !busy_i && cmd_ok |=> busy_i);
  a_r6_busy_during_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_i);
  a_r7_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && ctrl_wr |=> !mem_we_o);
  a_r7_needs_write_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !reg_wdata_i[BIT_WRITE] |=> !mem_we_o);
  a_r8_crc_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !(ctrl_wr && reg_wdata_i[BIT_CRC_CLR]) |=> $stable(crc_i));
  a_r9_crc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !busy_i && reg_wdata_i[BIT_CRC_CLR] |=> crc_i == 16'h0000);
endmodule

bind mbox_memwr mbox_memwr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mem_we_o(mem_we_o), .busy_i(busy), .crc_i(crc_val)
);

// File: tb/mbox_memwr_tb_top.sv
module mbox_memwr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [61:0] exp_q[$];
  logic [29:0] m_addr = '0;
  logic [15:0] m_crc = '0;

  always #2 clk = ~clk;

  mbox_memwr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [31:0] w);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [15:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, 64'(v), 64'(exp));
  endtask

  // driver: stage word, push expectation, command, then watch busy window (R6) and CRC (R8)
  task automatic commit(logic [31:0] d, logic [15:0] cmd);
    wr(16'h0204, d[31:16]);
    wr(16'h0205, d[15:0]);
    if (cmd[12]) m_crc = '0;
    exp_q.push_back({m_addr, d});
    m_crc = ref_crc(m_crc, d);
    m_addr = m_addr + 1'b1;
    wr(16'h0200, cmd);
    rd_chk("R6 busy first cycle", 16'h0200, 16'h0100);
    repeat (3) @(negedge clk);
    rd_chk("R6 busy fourth cycle", 16'h0200, 16'h0100);
    @(negedge clk);
    rd_chk("R6 busy cleared", 16'h0200, 16'h0000);
    rd_chk("R8 crc value", 16'h0201, m_crc);
  endtask

  // monitor: pop and compare every memory write (R4, R7)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected memory write", {2'b0, mem_addr, mem_wdata}, 64'h0);
      end else begin
        logic [61:0] e;
        e = exp_q.pop_front();
        check("R4 memory write", {2'b0, mem_addr, mem_wdata}, {2'b0, e});
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 16'h0200; a <= 16'h0205; a++) rd_chk("R1 reset value", 16'(a), 16'h0000);
    check("R1 mem_we low", 64'(mem_we), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 map and readback, unmapped access, read-only CRC
    wr(16'h0202, 16'h1234);
    wr(16'h0204, 16'hCAFE);
    wr(16'h0205, 16'hBEEF);
    rd_chk("R2 addr hi", 16'h0202, 16'h1234);
    rd_chk("R2 data hi", 16'h0204, 16'hCAFE);
    rd_chk("R2 data lo", 16'h0205, 16'hBEEF);
    wr(16'h0206, 16'h5555);
    wr(16'h0201, 16'hFFFF);
    rd_chk("R2 unmapped read", 16'h0206, 16'h0000);
    rd_chk("R2 unmapped write no effect", 16'h0205, 16'hBEEF);
    rd_chk("R8 crc not writable", 16'h0201, 16'h0000);

    // R3 low address bits dropped
    wr(16'h0203, 16'hABCF);
    rd_chk("R3 addr lo alignment", 16'h0203, 16'hABCC);

    // R7 execute without write, write without execute
    wr(16'h0200, 16'h8000);
    wr(16'h0200, 16'h4000);
    rd_chk("R7 no busy without write", 16'h0200, 16'h0000);

    // R4 R5 R8 burst from 0x1234_ABCC byte address
    m_addr = {16'h1234, 14'(16'hABCC >> 2)};
    commit(32'h3132_3334, 16'hC000);
    commit(32'h3536_3738, 16'hC000);
    commit(32'h0000_0000, 16'hC000);
    commit(32'hFFFF_FFFF, 16'hC000);
    rd_chk("R5 addr lo after burst", 16'h0203, 16'hABDC);
    rd_chk("R5 addr hi after burst", 16'h0202, 16'h1234);

    // R9 standalone clear
    wr(16'h0200, 16'h1000);
    m_crc = '0;
    rd_chk("R9 crc cleared", 16'h0201, 16'h0000);

    // R5 carry into upper half
    wr(16'h0202, 16'h0001);
    wr(16'h0203, 16'hFFFC);
    m_addr = {16'h0001, 14'h3FFF};
    commit(32'hDEAD_BEEF, 16'hC000);
    rd_chk("R5 carry hi", 16'h0202, 16'h0002);
    rd_chk("R5 carry lo", 16'h0203, 16'h0000);

    // R9 clear combined with commit
    commit(32'h0123_4567, 16'hD000);
    check("R9 combined crc", 64'(m_crc), 64'(ref_crc(16'h0, 32'h0123_4567)));

    // R7 commands during busy are dropped, including CRC clear
    wr(16'h0204, 16'h89AB);
    wr(16'h0205, 16'hCDEF);
    exp_q.push_back({m_addr, 32'h89AB_CDEF});
    m_crc = ref_crc(m_crc, 32'h89AB_CDEF);
    m_addr = m_addr + 1'b1;
    wr(16'h0200, 16'hC000);
    wr(16'h0200, 16'hD000);
    wr(16'h0200, 16'hC000);
    repeat (4) @(negedge clk);
    rd_chk("R7 idle after ignored commands", 16'h0200, 16'h0000);
    rd_chk("R7 crc not cleared while busy", 16'h0201, m_crc);
    rd_chk("R7 single address step", 16'h0203, 16'(m_addr[13:0]) << 2);

    repeat (4) @(negedge clk);
    check("R4 all writes seen", 64'(exp_q.size()), 64'h0);
    report();
  end
endmodule